// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block is the configuration front end of a multi-function peripheral chip. It watches byte writes arriving on an I/O-mapped configuration port. Its register file stays closed until a key byte, chosen by two strap pins, is written to that port twice in a row. Once open, the configuration port becomes an index register and the neighbouring data port reads and writes the indexed register. Through this pair, software selects a logical device and programs its enable bit, its I/O base address and its IRQ number. Four serial-port devices have full register sets. A watchdog device has only an enable. Writing the exit byte to the configuration port closes the register file again.

The host interface is a plain strobe pair, `wr_en` and `rd_en`, with a one-bit port select. There is no back-pressure: the block accepts one access of each kind in every cycle. A read strobe loads `rdata` on the next clock edge, and `rdata` holds that value until the next read. The per-device enables, bases and IRQ numbers are driven straight from their registers. The device logic consumes them.

Top module: `cfg_port_ctrl`

## Requirements
- R1: The entry key comes from `key_sel`, sampled in the cycle of each write: 2'b00 selects 0x77, 2'b01 selects 0xA0, 2'b10 selects 0x87 and 2'b11 selects 0x67. The reset-default strap value 2'b00 therefore gives 0x77.
- R2: The block opens only after two consecutive writes of the entry key to the configuration port (`port_sel`=0). A key write that follows a mismatched write counts as the first key of a new sequence.
- R3: While the block is closed, a write of any other value to the configuration port clears the sequence, and so does any write to the data port (`port_sel`=1). Data-port writes change no register, and reads from either port return 0xFF.
- R4: While the block is open, writing 0xAA to the configuration port closes it. Any other value written there becomes the index, and reading the configuration port returns the index.
- R5: A data-port write at index 0x07 selects the logical device, and a data-port read at index 0x07 returns it. Serial ports are devices 0 to 3 and the watchdog is device 8.
- R6: At index 0x30, bit 0 of a data write sets the selected device's enable. The enable output changes at the clock edge that captures the write, and a read returns the enable in bit 0 with the other bits zero.
- R7: Indices 0x60 and 0x61 hold bits 15:8 and 7:0 of a serial port's base. Written bits outside the mask 0x07F8 are dropped, so the base is 8-byte aligned and below 0x800. Reads return the masked value.
- R8: At index 0x70, the low four bits of a data write are stored as a serial port's IRQ number. Reads return it zero-extended.
- R9: For the watchdog, indices 0x60, 0x61 and 0x70 read 0x00 and ignore writes. For device numbers with no device behind them, every index other than 0x07 reads 0x00 and ignores writes. Unknown indices also read 0x00.
- R10: `rdata` is loaded at the clock edge that samples `rd_en` and is held otherwise. A write in the same cycle is not visible in that read.
- R11: A synchronous active-high reset closes the block, clears the sequence, selects device 0, sets the index to 0x00, and clears all enables, bases, IRQ numbers and `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_sel | input | 2 | Strap pins choosing the entry key |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| port_sel | input | 1 | 0 = configuration/index port, 1 = data port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| ser_en | output | NUM_SER | Serial-port enables |
| ser_base | output | 16*NUM_SER | Serial-port base addresses, port g at bits 16g+15:16g |
| ser_irq | output | IRQ_W*NUM_SER | Serial-port IRQ numbers |
| wdt_en | output | 1 | Watchdog enable |

## Verification
A read and a write may arrive in the same cycle. The read must then return the state from before the write: for example, the old base byte while a new one is written, or 0xFF while the second key byte opens the block. The bench provokes this case both directly and by giving independent random read and write strobes. It judges every read against a model that forms the read value before it applies the write. Relocking is checked the same way, since a read issued together with the 0xAA write must still return the index.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam logic [7:0] EXIT_KEY    = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_EN      = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  typedef enum logic [1:0] {
    ST_SHUT  = 2'd0,
    ST_HALF  = 2'd1,
    ST_OPEN  = 2'd2
  } unlock_st_t;

  function automatic logic [7:0] entry_key(input logic [1:0] sel);
    case (sel)
      2'b01:   return 8'hA0;
      2'b10:   return 8'h87;
      2'b11:   return 8'h67;
      default: return 8'h77;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_unlock.sv
module cfg_key_unlock
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] key_sel,
  input  logic       wr_en,
  input  logic       port_sel,
  input  logic [7:0] wdata,
  output logic       open
);

  unlock_st_t st_q;
  logic       key_hit;
  logic       exit_hit;

  assign key_hit  = !port_sel && (wdata == entry_key(key_sel));
  assign exit_hit = !port_sel && (wdata == EXIT_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_SHUT;
    end else if (wr_en) begin
      case (st_q)
        ST_SHUT: if (key_hit) st_q <= ST_HALF;
        ST_HALF: st_q <= key_hit ? ST_OPEN : ST_SHUT;
        ST_OPEN: if (exit_hit) st_q <= ST_SHUT;
        default: st_q <= ST_SHUT;
      endcase
    end
  end

  assign open = (st_q == ST_OPEN);

endmodule

// File: rtl/cfg_ser_bank.sv
module cfg_ser_bank
  import cfg_port_pkg::*;
#(
  parameter int          IRQ_W     = 4,
  parameter logic [15:0] BASE_MASK = 16'h07F8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  output logic             en,
  output logic [15:0]      base,
  output logic [IRQ_W-1:0] irq,
  output logic [7:0]       rd_val
);

  localparam logic [7:0] MASK_HI = BASE_MASK[15:8];
  localparam logic [7:0] MASK_LO = BASE_MASK[7:0];

  logic [7:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      hi_q <= '0;
      lo_q <= '0;
      irq  <= '0;
    end else if (wr_sel) begin
      case (idx)
        IDX_EN:      en   <= wdata[0];
        IDX_BASE_HI: hi_q <= wdata & MASK_HI;
        IDX_BASE_LO: lo_q <= wdata & MASK_LO;
        IDX_IRQ:     irq  <= wdata[IRQ_W-1:0];
        default:     ;
      endcase
    end
  end

  assign base = {hi_q, lo_q};

  always_comb begin
    case (idx)
      IDX_EN:      rd_val = {7'd0, en};
      IDX_BASE_HI: rd_val = hi_q;
      IDX_BASE_LO: rd_val = lo_q;
      IDX_IRQ:     rd_val = 8'(irq);
      default:     rd_val = 8'h00;
    endcase
  end

endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int          NUM_SER   = 4,
  parameter int          IRQ_W     = 4,
  parameter logic [15:0] BASE_MASK = 16'h07F8,
  parameter logic [7:0]  WDT_LDN   = 8'h08
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               key_sel,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     port_sel,
  input  logic [7:0]               wdata,
  output logic [7:0]               rdata,
  output logic [NUM_SER-1:0]       ser_en,
  output logic [NUM_SER*16-1:0]    ser_base,
  output logic [NUM_SER*IRQ_W-1:0] ser_irq,
  output logic                     wdt_en
);

  logic       cfg_open;
  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic       data_wr;
  logic [7:0] rd_next;
  logic [7:0] ser_rd [NUM_SER];

  cfg_key_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .key_sel  (key_sel),
    .wr_en    (wr_en),
    .port_sel (port_sel),
    .wdata    (wdata),
    .open     (cfg_open)
  );

  assign data_wr = cfg_open && wr_en && port_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (cfg_open && wr_en && !port_sel && (wdata != EXIT_KEY))
        idx_q <= wdata;
      if (data_wr && (idx_q == IDX_LDN))
        ldn_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_SER; g++) begin : g_ser
    logic wr_g;
    assign wr_g = data_wr && (ldn_q == 8'(g));

    cfg_ser_bank #(
      .IRQ_W     (IRQ_W),
      .BASE_MASK (BASE_MASK)
    ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_sel (wr_g),
      .idx    (idx_q),
      .wdata  (wdata),
      .en     (ser_en[g]),
      .base   (ser_base[g*16 +: 16]),
      .irq    (ser_irq[g*IRQ_W +: IRQ_W]),
      .rd_val (ser_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      wdt_en <= 1'b0;
    else if (data_wr && (ldn_q == WDT_LDN) && (idx_q == IDX_EN))
      wdt_en <= wdata[0];
  end

  always_comb begin
    rd_next = 8'h00;
    if (!cfg_open) begin
      rd_next = LOCKED_READ;
    end else if (!port_sel) begin
      rd_next = idx_q;
    end else if (idx_q == IDX_LDN) begin
      rd_next = ldn_q;
    end else if ((ldn_q == WDT_LDN) && (idx_q == IDX_EN)) begin
      rd_next = {7'd0, wdt_en};
    end else begin
      for (int i = 0; i < NUM_SER; i++)
        if (ldn_q == 8'(i)) rd_next = ser_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_next;
  end

endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk
  import cfg_port_pkg::*;
#(
  parameter int          NUM_SER   = 4,
  parameter logic [15:0] BASE_MASK = 16'h07F8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            key_sel,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  port_sel,
  input  logic [7:0]            wdata,
  input  logic [7:0]            rdata,
  input  logic [NUM_SER-1:0]    ser_en,
  input  logic [NUM_SER*16-1:0] ser_base,
  input  logic                  wdt_en,
  input  logic                  open_i
);

  localparam logic [NUM_SER*16-1:0] BAD_BITS = {NUM_SER{~BASE_MASK}};

  assert_unlock_by_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(open_i) |-> $past(wr_en && !port_sel && (wdata == entry_key(key_sel))));

  assert_locked_read_ff_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !open_i) |=> (rdata == LOCKED_READ));

  assert_locked_no_change_R3: assert property (@(posedge clk) disable iff (rst)
    !open_i |=> ($stable(ser_en) && $stable(ser_base) && $stable(wdt_en)));

  assert_exit_relocks_R4: assert property (@(posedge clk) disable iff (rst)
    (open_i && wr_en && !port_sel && (wdata == EXIT_KEY)) |=> !open_i);

  assert_base_masked_R7: assert property (@(posedge clk) disable iff (rst)
    ((ser_base & BAD_BITS) == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
  .NUM_SER   (NUM_SER),
  .BASE_MASK (BASE_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .key_sel  (key_sel),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .port_sel (port_sel),
  .wdata    (wdata),
  .rdata    (rdata),
  .ser_en   (ser_en),
  .ser_base (ser_base),
  .wdt_en   (wdt_en),
  .open_i   (cfg_open)
);

// File: tb/cfg_port_ctrl_bench.sv
module cfg_port_ctrl_bench;

  localparam int NS = 4;
  localparam int IW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      key_sel = 2'b00;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic            port_sel = 1'b0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic [NS-1:0]   ser_en;
  logic [NS*16-1:0] ser_base;
  logic [NS*IW-1:0] ser_irq;
  logic            wdt_en;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cfg_port_ctrl u_cfg_port_ctrl (
    .clk(clk), .rst(rst), .key_sel(key_sel), .wr_en(wr_en), .rd_en(rd_en),
    .port_sel(port_sel), .wdata(wdata), .rdata(rdata), .ser_en(ser_en),
    .ser_base(ser_base), .ser_irq(ser_irq), .wdt_en(wdt_en)
  );

  // reference model state
  logic        m_open, m_half, m_wdt;
  logic [7:0]  m_idx, m_ldn, m_rdata;
  logic        m_en   [NS];
  logic [15:0] m_base [NS];
  logic [3:0]  m_irq  [NS];

  function automatic logic [7:0] key_of(input logic [1:0] s);
    case (s)
      2'b00: return 8'h77;
      2'b01: return 8'hA0;
      2'b10: return 8'h87;
      default: return 8'h67;
    endcase
  endfunction

  task automatic model_reset();
    m_open = 0; m_half = 0; m_wdt = 0; m_idx = 0; m_ldn = 0; m_rdata = 0;
    for (int i = 0; i < NS; i++) begin m_en[i] = 0; m_base[i] = 0; m_irq[i] = 0; end
  endtask

  function automatic logic [7:0] model_read(input logic p);
    if (!m_open) return 8'hFF;
    if (!p) return m_idx;
    if (m_idx == 8'h07) return m_ldn;
    if (m_ldn < NS) begin
      case (m_idx)
        8'h30: return {7'd0, m_en[m_ldn]};
        8'h60: return m_base[m_ldn][15:8];
        8'h61: return m_base[m_ldn][7:0];
        8'h70: return {4'd0, m_irq[m_ldn]};
        default: return 8'h00;
      endcase
    end
    if (m_ldn == 8'h08 && m_idx == 8'h30) return {7'd0, m_wdt};
    return 8'h00;
  endfunction

  task automatic model_write(input logic p, input logic [7:0] d);
    if (!m_open) begin
      if (!p && d == key_of(key_sel)) begin
        if (m_half) begin m_open = 1; m_half = 0; end
        else m_half = 1;
      end else m_half = 0;
    end else if (!p) begin
      if (d == 8'hAA) m_open = 0; else m_idx = d;
    end else if (m_idx == 8'h07) begin
      m_ldn = d;
    end else if (m_ldn < NS) begin
      case (m_idx)
        8'h30: m_en[m_ldn] = d[0];
        8'h60: m_base[m_ldn][15:8] = d & 8'h07;
        8'h61: m_base[m_ldn][7:0] = d & 8'hF8;
        8'h70: m_irq[m_ldn] = d[3:0];
        default: ;
      endcase
    end else if (m_ldn == 8'h08 && m_idx == 8'h30) begin
      m_wdt = d[0];
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [NS-1:0]    e_en;
    logic [NS*16-1:0] e_base;
    logic [NS*IW-1:0] e_irq;
    for (int i = 0; i < NS; i++) begin
      e_en[i] = m_en[i];
      e_base[i*16 +: 16] = m_base[i];
      e_irq[i*IW +: IW] = m_irq[i];
    end
    checks++;
    if (rdata !== m_rdata) begin
      fails++;
      $display("FAIL %s rdata: actual %02h expected %02h", tag, rdata, m_rdata);
    end
    checks++;
    if (ser_en !== e_en || ser_base !== e_base || ser_irq !== e_irq || wdt_en !== m_wdt) begin
      fails++;
      $display("FAIL %s outputs: actual en=%h base=%h irq=%h wdt=%b expected en=%h base=%h irq=%h wdt=%b",
               tag, ser_en, ser_base, ser_irq, wdt_en, e_en, e_base, e_irq, m_wdt);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic p,
                      input logic [7:0] d, input string tag);
    logic [7:0] exp_rd;
    wr_en = w; rd_en = r; port_sel = p; wdata = d;
    exp_rd = model_read(p);
    if (r) m_rdata = exp_rd;
    if (w) model_write(p, d);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check_outputs(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1; wr_en = 0; rd_en = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 0;
    check_outputs(tag);
  endtask

  task automatic unlock(input string tag);
    step(1, 0, 0, key_of(key_sel), tag);
    step(1, 0, 0, key_of(key_sel), tag);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d, input string tag);
    step(1, 0, 0, i, tag);
    step(1, 0, 1, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset("R11 reset state");
    step(0, 1, 1, 8'h00, "R3 locked data read 0xFF");
    step(0, 1, 0, 8'h00, "R3 locked index read 0xFF");

    // R1: every strap value opens with its own key only
    for (int s = 0; s < 4; s++) begin
      key_sel = 2'(s);
      step(1, 0, 0, key_of(2'(s + 1)), "R1 wrong key");
      step(1, 1, 0, key_of(2'(s + 1)), "R1 wrong key stays shut");
      unlock("R1 strap key");
      step(0, 1, 0, 8'h00, "R1 open after two keys");
      step(1, 1, 0, 8'hAA, "R4 read beside exit write");
      step(0, 1, 0, 8'h00, "R4 relocked reads 0xFF");
    end

    key_sel = 2'b00;
    // R2: mismatch in the middle, then key as fresh first
    step(1, 0, 0, 8'h77, "R2 first key");
    step(1, 0, 0, 8'h12, "R2 mismatch");
    step(1, 1, 0, 8'h77, "R2 key after mismatch is first");
    step(1, 1, 0, 8'h77, "R2 second key opens, read same cycle 0xFF");
    step(0, 1, 0, 8'h00, "R2 open");
    step(1, 0, 0, 8'hAA, "R4 exit");
    // R3: data write between keys breaks sequence and changes nothing
    step(1, 0, 0, 8'h77, "R3 key");
    step(1, 0, 1, 8'h01, "R3 locked data write");
    step(1, 1, 0, 8'h77, "R3 key after data write");
    step(0, 1, 1, 8'h00, "R3 still locked");
    step(1, 0, 0, 8'h77, "R3 second key opens");

    // R5..R8 program device 2
    reg_wr(8'h07, 8'h02, "R5 select device 2");
    step(0, 1, 1, 8'h00, "R5 device readback");
    reg_wr(8'h30, 8'h00, "R6 disable");
    reg_wr(8'h60, 8'hFF, "R7 base high masked");
    step(0, 1, 1, 8'h00, "R7 high readback");
    reg_wr(8'h61, 8'hFF, "R7 base low masked");
    step(0, 1, 1, 8'h00, "R7 low readback");
    step(1, 1, 1, 8'h18, "R10 read returns old byte beside write");
    step(0, 1, 1, 8'h00, "R10 new byte visible");
    step(0, 0, 1, 8'h00, "R10 rdata holds");
    reg_wr(8'h30, 8'hFF, "R6 enable follows write");
    step(0, 1, 1, 8'h00, "R6 enable readback");
    reg_wr(8'h70, 8'h7D, "R8 irq low bits");
    step(0, 1, 1, 8'h00, "R8 irq readback");
    // R9 watchdog and empty device numbers
    reg_wr(8'h07, 8'h08, "R9 select watchdog");
    reg_wr(8'h30, 8'h01, "R6 watchdog enable");
    step(0, 1, 1, 8'h00, "R6 watchdog readback");
    reg_wr(8'h60, 8'h05, "R9 watchdog base ignored");
    step(0, 1, 1, 8'h00, "R9 watchdog base reads 0");
    reg_wr(8'h07, 8'h05, "R9 select empty device");
    reg_wr(8'h30, 8'h01, "R9 empty enable ignored");
    step(0, 1, 1, 8'h00, "R9 empty reads 0");
    reg_wr(8'h07, 8'h01, "R9 back to device 1");
    reg_wr(8'h44, 8'h3C, "R9 unknown index ignored");
    step(0, 1, 1, 8'h00, "R9 unknown index reads 0");
    step(0, 1, 0, 8'h00, "R4 index readback");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] d;
      int r;
      if ($urandom % 50 == 0) key_sel = 2'($urandom);
      r = $urandom % 12;
      case (r)
        0, 1, 2: d = key_of(key_sel);
        3:       d = 8'hAA;
        4, 5, 6: begin
          int k = $urandom % 6;
          d = (k == 0) ? 8'h07 : (k == 1) ? 8'h30 : (k == 2) ? 8'h60 :
              (k == 3) ? 8'h61 : (k == 4) ? 8'h70 : 8'h10;
        end
        7, 8:    d = 8'($urandom % 10);
        default: d = 8'($urandom);
      endcase
      step(($urandom % 10) < 8, ($urandom % 2) == 1, ($urandom % 2) == 1, d,
           "random R2 R3 R4 R5 R6 R7 R8 R9 R10");
      if (n == 2000) do_reset("R11 mid-run reset");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule